// File: doc/BRIEF.md
# Voice Group Playback Sequencer

This block plays one voice group at a time out of a synchronous sample memory. A voice group is an ordered list of table entries. Each entry names one fixed-size memory block. Because playback goes through this list of block indices, one stored run of blocks can be reused by several groups and placed in any order. A run may appear in the middle of one group and at the head of another.

A start request carries a group number. The sequencer reads that group's descriptor, then walks its table entries in order. For each entry it reads every byte of the named block and hands out one sample on each sample tick. A group is stored either as 8-bit PCM, with one sample per byte, or as 4-bit ADPCM, with two samples per byte. The ADPCM nibbles are passed on undecoded. If ramping is selected, the output first climbs one step per tick from mid-scale to the first sample and finally falls back to mid-scale, so no step appears at the speaker. Busy and a one-cycle done pulse frame each playback. A stop request ends playback early, and the reset input ends it at once.

Top module: `vgrp_player`

## Requirements
- R1: After a start request is accepted while idle, busy_o is high in the next cycle. busy_o stays high until playback ends.
- R2: A start request seen while busy_o is high is ignored. The running group's sample stream is unchanged.
- R3: The descriptor word holds the sample format in bit 20, the first table entry in bits 19:10 and the entry count in bits 9:0. Entries are played from the first entry upward. The memory byte address is the block index times the block size plus the byte offset. Bytes within a block are read in rising offset order, and the memory is never read while busy_o is low.
- R4: In PCM format (format bit 0), each byte is presented on sample_o as one sample. smp_vld_o pulses only in the cycle after a tick.
- R5: In ADPCM format (format bit 1), each byte gives two samples. The high nibble comes first, then the low nibble, each on its own tick. The nibble is presented as 0x0N.
- R6: With ramp_en_i high at start, the output moves from 0x80 one LSB per tick toward the first sample. The tick that finds the output equal to the first sample presents that sample and begins playback.
- R7: With ramping, after the last sample the output moves one LSB per tick back to 0x80. The first tick that finds 0x80 raises done_o, with no sample pulse in that cycle.
- R8: Without ramping, done_o pulses in the same cycle as the last sample's smp_vld_o, and busy_o is already low in that cycle. Whenever busy_o and done_o are both low, sample_o is 0x80.
- R9: A stop request without ramping ends playback at the next edge: busy_o is low and done_o is high in the following cycle. With ramping, a stop starts the ramp down from the current output, and busy_o stays high while the output ramps down.
- R10: Reset ends playback at the next edge. busy_o is then low and sample_o is 0x80, with no done pulse and no further samples or memory reads.
- R11: A group with an entry count of zero produces no samples. It ends with a done pulse.
- R12: done_o is a single-cycle pulse, exactly one per accepted start, raised in the first cycle with busy_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, stops playback |
| tick_i | input | 1 | Sample-rate tick, one cycle wide |
| start_i | input | 1 | Start request for group grp_i |
| stop_i | input | 1 | Stop request |
| grp_i | input | 5 | Group number for start |
| ramp_en_i | input | 1 | Enable ramp up/down, latched at start |
| desc_addr_o | output | 5 | Descriptor read address (group) |
| desc_data_i | input | 21 | Descriptor word, one cycle after address |
| tbl_addr_o | output | 10 | Combination table entry address |
| tbl_data_i | input | 8 | Block index, one cycle after address |
| mem_rd_o | output | 1 | Sample memory read strobe |
| mem_addr_o | output | 17 | Sample memory byte address |
| mem_data_i | input | 8 | Sample byte, one cycle after the strobe |
| sample_o | output | 8 | Current output sample |
| smp_vld_o | output | 1 | New sample presented this cycle |
| busy_o | output | 1 | Playback in progress |
| done_o | output | 1 | One-cycle end-of-playback pulse |

## Verification
A wrong table pointer or byte offset shows up at once as a wrong value in the collected sample stream, from the first tick after the bad fetch. A wrong nibble selector or ramp state shows up as a reordered nibble pair or a ramp step larger than one LSB, again on the next sample pulse. Faults in the end-of-playback logic show up as done_o in the wrong cycle relative to busy_o and the last sample, or as mid-scale missing in the cycle after done. A fetch unit that fails to abort is caught by a memory strobe while busy_o is low.

// File: rtl/vgrp_pkg.sv
package vgrp_pkg;

    localparam logic [7:0] MID_SCALE = 8'h80;

    typedef enum logic [2:0] {
        F_IDLE, F_DESC, F_DWAIT, F_TBL, F_TWAIT, F_MEM, F_MWAIT, F_FULL
    } fetch_st_e;

    typedef enum logic [1:0] {
        E_IDLE, E_UP, E_PLAY, E_DOWN
    } emit_st_e;

    typedef struct packed {
        logic       vld;
        logic       last;
        logic [7:0] data;
    } byte_slot_t;

    // One LSB toward target; unchanged when already equal.
    function automatic logic [7:0] step_toward(input logic [7:0] cur, input logic [7:0] tgt);
        if (cur < tgt)      return cur + 8'd1;
        else if (cur > tgt) return cur - 8'd1;
        return cur;
    endfunction

    // Sample value taken from a stored byte.
    function automatic logic [7:0] pick_sample(input logic [7:0] b, input logic nib_mode,
                                               input logic low_half);
        if (!nib_mode) return b;
        return low_half ? {4'h0, b[3:0]} : {4'h0, b[7:4]};
    endfunction

endpackage

// File: rtl/vgrp_fetch.sv
module vgrp_fetch
    import vgrp_pkg::*;
#(
    parameter int GRP_W     = 5,
    parameter int ENT_W     = 10,
    parameter int BLK_IDX_W = 8,
    parameter int BLK_BYTES = 512,
    localparam int OFF_W    = $clog2(BLK_BYTES),
    localparam int DESC_W   = 1 + 2 * ENT_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     go_i,
    input  logic                     abort_i,
    input  logic [GRP_W-1:0]         grp_i,
    input  logic                     pop_i,
    output logic [GRP_W-1:0]         desc_addr_o,
    input  logic [DESC_W-1:0]        desc_data_i,
    output logic [ENT_W-1:0]         tbl_addr_o,
    input  logic [BLK_IDX_W-1:0]     tbl_data_i,
    output logic                     mem_rd_o,
    output logic [BLK_IDX_W+OFF_W-1:0] mem_addr_o,
    input  logic [7:0]               mem_data_i,
    output byte_slot_t               slot_o,
    output logic                     nib_mode_o,
    output logic                     empty_o
);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(BLK_BYTES - 1);

    fetch_st_e              st;
    logic [GRP_W-1:0]       grp_q;
    logic [ENT_W-1:0]       ent_ptr;
    logic [ENT_W-1:0]       ent_left;
    logic [BLK_IDX_W-1:0]   blk;
    logic [OFF_W-1:0]       off;
    logic                   nib_q;
    byte_slot_t             slot;

    logic                   d_nib;
    logic [ENT_W-1:0]       d_first;
    logic [ENT_W-1:0]       d_cnt;

    assign d_nib   = desc_data_i[DESC_W-1];
    assign d_first = desc_data_i[2*ENT_W-1:ENT_W];
    assign d_cnt   = desc_data_i[ENT_W-1:0];

    assign desc_addr_o = grp_q;
    assign tbl_addr_o  = ent_ptr;
    assign mem_addr_o  = {blk, off};
    assign mem_rd_o    = (st == F_MEM);
    assign slot_o      = slot;
    assign nib_mode_o  = nib_q;
    assign empty_o     = (st == F_DWAIT) && (d_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= F_IDLE;
            grp_q    <= '0;
            ent_ptr  <= '0;
            ent_left <= '0;
            blk      <= '0;
            off      <= '0;
            nib_q    <= 1'b0;
            slot     <= '0;
        end else if (abort_i) begin
            st       <= F_IDLE;
            slot.vld <= 1'b0;
        end else begin
            case (st)
                F_IDLE: if (go_i) begin
                    grp_q    <= grp_i;
                    slot.vld <= 1'b0;
                    st       <= F_DESC;
                end
                F_DESC:  st <= F_DWAIT;
                F_DWAIT: begin
                    nib_q    <= d_nib;
                    ent_ptr  <= d_first;
                    ent_left <= d_cnt;
                    st       <= (d_cnt == '0) ? F_IDLE : F_TBL;
                end
                F_TBL:   st <= F_TWAIT;
                F_TWAIT: begin
                    blk <= tbl_data_i;
                    off <= '0;
                    st  <= F_MEM;
                end
                F_MEM:   st <= F_MWAIT;
                F_MWAIT: begin
                    slot.vld  <= 1'b1;
                    slot.last <= (ent_left == ENT_W'(1)) && (off == OFF_LAST);
                    slot.data <= mem_data_i;
                    st        <= F_FULL;
                end
                F_FULL: if (pop_i) begin
                    slot.vld <= 1'b0;
                    if (slot.last) begin
                        st <= F_IDLE;
                    end else if (off == OFF_LAST) begin
                        ent_ptr  <= ent_ptr + ENT_W'(1);
                        ent_left <= ent_left - ENT_W'(1);
                        st       <= F_TBL;
                    end else begin
                        off <= off + OFF_W'(1);
                        st  <= F_MEM;
                    end
                end
                default: st <= F_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vgrp_emit.sv
module vgrp_emit
    import vgrp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       ramp_i,
    input  logic       nib_mode_i,
    input  byte_slot_t slot_i,
    input  logic       empty_i,
    output logic [7:0] sample_o,
    output logic       vld_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       pop_o,
    output logic       fin_o
);
    emit_st_e   st;
    logic [7:0] out_q;
    logic       nib_lo;
    logic       ramp_q;
    logic       vld_q;
    logic       done_q;

    logic [7:0] cur;
    logic       can_take;
    logic       take;
    logic       last_take;
    logic       playing;

    assign playing   = (st == E_UP) || (st == E_PLAY);
    assign cur       = pick_sample(slot_i.data, nib_mode_i, nib_lo);
    assign can_take  = tick_i && slot_i.vld;
    assign take      = can_take && ((st == E_PLAY) || ((st == E_UP) && (out_q == cur)));
    assign pop_o     = playing && !stop_i && take && (!nib_mode_i || nib_lo);
    assign last_take = pop_o && slot_i.last;
    assign fin_o     = (playing && (empty_i || (stop_i && !ramp_q) || (last_take && !ramp_q)))
                     || ((st == E_DOWN) && tick_i && (out_q == MID_SCALE));

    assign sample_o = out_q;
    assign vld_o    = vld_q;
    assign done_o   = done_q;
    assign busy_o   = (st != E_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= E_IDLE;
            out_q  <= MID_SCALE;
            nib_lo <= 1'b0;
            ramp_q <= 1'b0;
            vld_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            vld_q  <= 1'b0;
            done_q <= 1'b0;
            case (st)
                E_IDLE: begin
                    out_q <= MID_SCALE;
                    if (start_i) begin
                        st     <= ramp_i ? E_UP : E_PLAY;
                        ramp_q <= ramp_i;
                        nib_lo <= 1'b0;
                    end
                end
                E_UP, E_PLAY: begin
                    if (empty_i) begin
                        st     <= E_IDLE;
                        done_q <= 1'b1;
                    end else if (stop_i) begin
                        if (ramp_q) begin
                            st <= E_DOWN;
                        end else begin
                            st     <= E_IDLE;
                            done_q <= 1'b1;
                        end
                    end else if (take) begin
                        out_q  <= cur;
                        vld_q  <= 1'b1;
                        nib_lo <= nib_mode_i && !nib_lo;
                        if (last_take) begin
                            if (ramp_q) begin
                                st <= E_DOWN;
                            end else begin
                                st     <= E_IDLE;
                                done_q <= 1'b1;
                            end
                        end else begin
                            st <= E_PLAY;
                        end
                    end else if ((st == E_UP) && can_take) begin
                        out_q <= step_toward(out_q, cur);
                        vld_q <= 1'b1;
                    end
                end
                E_DOWN: if (tick_i) begin
                    if (out_q == MID_SCALE) begin
                        st     <= E_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        out_q <= step_toward(out_q, MID_SCALE);
                        vld_q <= 1'b1;
                    end
                end
                default: st <= E_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vgrp_player.sv
module vgrp_player
    import vgrp_pkg::*;
#(
    parameter int NUM_GROUPS = 32,
    parameter int TBL_DEPTH  = 960,
    parameter int BLK_BYTES  = 512,
    parameter int BLK_IDX_W  = 8,
    localparam int GRP_W     = $clog2(NUM_GROUPS),
    localparam int ENT_W     = $clog2(TBL_DEPTH + 1),
    localparam int OFF_W     = $clog2(BLK_BYTES),
    localparam int ADDR_W    = BLK_IDX_W + OFF_W,
    localparam int DESC_W    = 1 + 2 * ENT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_i,
    input  logic                 start_i,
    input  logic                 stop_i,
    input  logic [GRP_W-1:0]     grp_i,
    input  logic                 ramp_en_i,
    output logic [GRP_W-1:0]     desc_addr_o,
    input  logic [DESC_W-1:0]    desc_data_i,
    output logic [ENT_W-1:0]     tbl_addr_o,
    input  logic [BLK_IDX_W-1:0] tbl_data_i,
    output logic                 mem_rd_o,
    output logic [ADDR_W-1:0]    mem_addr_o,
    input  logic [7:0]           mem_data_i,
    output logic [7:0]           sample_o,
    output logic                 smp_vld_o,
    output logic                 busy_o,
    output logic                 done_o
);
    logic       accept;
    logic       abort;
    logic       pop;
    logic       fin;
    logic       empty;
    logic       nib_mode;
    byte_slot_t slot;

    assign accept = start_i && !busy_o;
    assign abort  = fin || (stop_i && busy_o);

    vgrp_fetch #(
        .GRP_W     (GRP_W),
        .ENT_W     (ENT_W),
        .BLK_IDX_W (BLK_IDX_W),
        .BLK_BYTES (BLK_BYTES)
    ) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .go_i        (accept),
        .abort_i     (abort),
        .grp_i       (grp_i),
        .pop_i       (pop),
        .desc_addr_o (desc_addr_o),
        .desc_data_i (desc_data_i),
        .tbl_addr_o  (tbl_addr_o),
        .tbl_data_i  (tbl_data_i),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .mem_data_i  (mem_data_i),
        .slot_o      (slot),
        .nib_mode_o  (nib_mode),
        .empty_o     (empty)
    );

    vgrp_emit u_emit (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .start_i    (accept),
        .stop_i     (stop_i),
        .ramp_i     (ramp_en_i),
        .nib_mode_i (nib_mode),
        .slot_i     (slot),
        .empty_i    (empty),
        .sample_o   (sample_o),
        .vld_o      (smp_vld_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .pop_o      (pop),
        .fin_o      (fin)
    );

endmodule

// File: rtl/vgrp_player_chk.sv
module vgrp_player_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick_i,
    input logic       start_i,
    input logic       busy_o,
    input logic       smp_vld_o,
    input logic       done_o,
    input logic [7:0] sample_o,
    input logic       mem_rd_o
);
    assert_busy_rise_R1: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    assert_quiet_memory_R3: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> busy_o);

    assert_vld_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        smp_vld_o |-> $past(tick_i));

    assert_rest_midscale_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !done_o) |-> (sample_o == 8'h80));

    assert_done_at_end_R12: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_done_single_R12: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

bind vgrp_player vgrp_player_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick_i),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .smp_vld_o (smp_vld_o),
    .done_o    (done_o),
    .sample_o  (sample_o),
    .mem_rd_o  (mem_rd_o)
);

// File: tb/vgrp_player_tb.sv
module vgrp_player_tb;
    localparam int BLK_B  = 8;
    localparam int ADDR_W = 8 + $clog2(BLK_B);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_i = 1'b0;
    logic              start_i = 1'b0;
    logic              stop_i = 1'b0;
    logic [4:0]        grp_i = '0;
    logic              ramp_en_i = 1'b0;
    logic [4:0]        desc_addr_o;
    logic [20:0]       desc_data_i;
    logic [9:0]        tbl_addr_o;
    logic [7:0]        tbl_data_i;
    logic              mem_rd_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [7:0]        mem_data_i;
    logic [7:0]        sample_o;
    logic              smp_vld_o;
    logic              busy_o;
    logic              done_o;

    int total = 0;
    int bad   = 0;

    logic [20:0] desc_mem [0:31];
    logic [7:0]  tbl_mem  [0:959];
    logic [7:0]  got_q [$];
    logic [7:0]  exp_q [$];
    int          done_cnt = 0;
    logic [7:0]  done_smp;
    logic        done_vld;
    int          rd_cnt = 0;

    always #4 clk = ~clk;

    vgrp_player #(.BLK_BYTES(BLK_B)) u_dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .start_i(start_i), .stop_i(stop_i),
        .grp_i(grp_i), .ramp_en_i(ramp_en_i),
        .desc_addr_o(desc_addr_o), .desc_data_i(desc_data_i),
        .tbl_addr_o(tbl_addr_o), .tbl_data_i(tbl_data_i),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
        .sample_o(sample_o), .smp_vld_o(smp_vld_o), .busy_o(busy_o), .done_o(done_o)
    );

    function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
        return 8'((int'(a) * 29 + 59) & 255);
    endfunction

    always @(posedge clk) begin
        desc_data_i <= desc_mem[desc_addr_o];
        tbl_data_i  <= tbl_mem[tbl_addr_o];
        mem_data_i  <= mem_byte(mem_addr_o);
    end

    // tick every 6 cycles
    initial begin
        forever begin
            @(negedge clk) tick_i = 1'b1;
            @(negedge clk) tick_i = 1'b0;
            repeat (4) @(negedge clk);
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (smp_vld_o) got_q.push_back(sample_o);
            if (done_o) begin
                done_cnt++;
                done_smp = sample_o;
                done_vld = smp_vld_o;
            end
            if (mem_rd_o) rd_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] step1(input logic [7:0] c, input logic [7:0] t);
        if (c < t) return c + 8'd1;
        if (c > t) return c - 8'd1;
        return c;
    endfunction

    task automatic build_expect(input int g, input bit ramp);
        logic [20:0] d;
        logic [7:0]  raw [$];
        logic [7:0]  o;
        d = desc_mem[g];
        exp_q.delete();
        for (int e = 0; e < int'(d[9:0]); e++) begin
            for (int k = 0; k < BLK_B; k++) begin
                logic [7:0] b;
                b = mem_byte({tbl_mem[int'(d[19:10]) + e], 3'(k)});
                if (d[20]) begin
                    raw.push_back({4'h0, b[7:4]});
                    raw.push_back({4'h0, b[3:0]});
                end else begin
                    raw.push_back(b);
                end
            end
        end
        o = 8'h80;
        if (ramp && raw.size() > 0) begin
            while (o != raw[0]) begin o = step1(o, raw[0]); exp_q.push_back(o); end
        end
        foreach (raw[i]) exp_q.push_back(raw[i]);
        if (ramp && raw.size() > 0) begin
            o = raw[raw.size()-1];
            while (o != 8'h80) begin o = step1(o, 8'h80); exp_q.push_back(o); end
        end
    endtask

    task automatic clear_obs();
        got_q.delete();
        done_cnt = 0;
        done_vld = 1'b0;
        done_smp = 8'h00;
    endtask

    task automatic launch(input int g, input bit ramp);
        @(negedge clk);
        grp_i = 5'(g); ramp_en_i = ramp; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input string req);
        for (int i = 0; i < 8000 && done_cnt == 0; i++) @(negedge clk);
        chk(done_cnt != 0, req, "playback end reached", done_cnt, 1);
    endtask

    task automatic cmp_stream(input string req);
        int mism;
        mism = -1;
        chk(got_q.size() == exp_q.size(), req, "sample count", got_q.size(), exp_q.size());
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
            if (mism < 0 && got_q[i] != exp_q[i]) mism = i;
        if (mism >= 0) chk(1'b0, req, $sformatf("sample %0d", mism), got_q[mism], exp_q[mism]);
        else           chk(1'b1, req, "sample values", 0, 0);
    endtask

    task automatic t_reset_state();
        chk(busy_o == 1'b0, "R10", "busy after reset", busy_o, 0);
        chk(sample_o == 8'h80, "R10", "sample after reset", sample_o, 8'h80);
        chk(smp_vld_o == 1'b0 && done_o == 1'b0, "R10", "vld/done after reset", {smp_vld_o, done_o}, 0);
    endtask

    // R3 R4 R8: concatenated runs 13-15 then 0-2, PCM, no ramp
    task automatic t_pcm_concat();
        clear_obs(); build_expect(1, 1'b0);
        launch(1, 1'b0);
        chk(busy_o == 1'b1, "R1", "busy one cycle after start", busy_o, 1);
        wait_done("R8");
        cmp_stream("R3");
        chk(done_vld == 1'b1, "R8", "done with last sample pulse", done_vld, 1);
        chk(done_smp == exp_q[exp_q.size()-1], "R8", "sample in done cycle", done_smp, exp_q[exp_q.size()-1]);
        @(negedge clk);
        chk(sample_o == 8'h80 && busy_o == 1'b0, "R8", "mid-scale after done", sample_o, 8'h80);
        chk(done_cnt == 1, "R12", "one done pulse", done_cnt, 1);
    endtask

    task automatic t_shared_run();
        clear_obs(); build_expect(2, 1'b0);
        launch(2, 1'b0);
        wait_done("R3");
        cmp_stream("R3");
    endtask

    task automatic t_adpcm();
        clear_obs(); build_expect(3, 1'b0);
        launch(3, 1'b0);
        wait_done("R5");
        cmp_stream("R5");
        chk(got_q.size() == 2 * 2 * BLK_B, "R5", "two nibbles per byte", got_q.size(), 4 * BLK_B);
    endtask

    task automatic t_ramp(input int g, input string req);
        clear_obs(); build_expect(g, 1'b1);
        launch(g, 1'b1);
        wait_done(req);
        cmp_stream(req);
        chk(done_vld == 1'b0, "R7", "no sample pulse with done", done_vld, 0);
        chk(done_smp == 8'h80, "R7", "output at mid-scale at done", done_smp, 8'h80);
        chk(done_cnt == 1, "R12", "one done pulse", done_cnt, 1);
    endtask

    task automatic t_retrigger();
        clear_obs(); build_expect(1, 1'b0);
        launch(1, 1'b0);
        repeat (30) @(negedge clk);
        grp_i = 5'd2; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done("R2");
        cmp_stream("R2");
        chk(done_cnt == 1, "R2", "single playback", done_cnt, 1);
    endtask

    task automatic t_stop_plain();
        int n;
        clear_obs(); build_expect(1, 1'b0);
        launch(1, 1'b0);
        repeat (60) @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk(busy_o == 1'b0 && done_o == 1'b1, "R9", "stop ends at next edge", {busy_o, done_o}, 1);
        @(negedge clk);
        chk(sample_o == 8'h80, "R9", "mid-scale after stop", sample_o, 8'h80);
        n = got_q.size();
        chk(n > 0 && n < exp_q.size(), "R9", "stream cut short", n, exp_q.size());
        repeat (30) @(negedge clk);
        chk(got_q.size() == n && done_cnt == 1, "R9", "nothing after stop", got_q.size(), n);
    endtask

    task automatic t_stop_ramp();
        clear_obs();
        launch(1, 1'b1);
        repeat (60) @(negedge clk);
        stop_i = 1'b1;
        @(negedge clk);
        stop_i = 1'b0;
        chk(busy_o == 1'b1, "R9", "busy held during ramp down", busy_o, 1);
        wait_done("R9");
        chk(got_q.size() > 0 && got_q[got_q.size()-1] == 8'h80, "R9", "ramp down ends at mid-scale",
            got_q.size() > 0 ? got_q[got_q.size()-1] : 0, 8'h80);
        chk(done_cnt == 1, "R12", "one done after ramp stop", done_cnt, 1);
    endtask

    task automatic t_reset_mid();
        int n;
        int r;
        clear_obs();
        launch(1, 1'b0);
        repeat (40) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(busy_o == 1'b0 && sample_o == 8'h80, "R10", "reset stops at once", sample_o, 8'h80);
        n = got_q.size();
        r = rd_cnt;
        repeat (40) @(negedge clk);
        chk(got_q.size() == n && done_cnt == 0 && rd_cnt == r, "R10", "silent after reset",
            got_q.size() - n + done_cnt + rd_cnt - r, 0);
    endtask

    task automatic t_empty();
        clear_obs();
        launch(4, 1'b1);
        chk(busy_o == 1'b1, "R1", "busy for empty group", busy_o, 1);
        wait_done("R11");
        chk(got_q.size() == 0, "R11", "no samples from empty group", got_q.size(), 0);
    endtask

    task automatic t_last_entry();
        clear_obs(); build_expect(5, 1'b0);
        launch(5, 1'b0);
        wait_done("R3");
        cmp_stream("R3");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired: actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        foreach (desc_mem[i]) desc_mem[i] = '0;
        foreach (tbl_mem[i])  tbl_mem[i]  = '0;
        tbl_mem[0] = 8'd13; tbl_mem[1] = 8'd14; tbl_mem[2] = 8'd15;
        tbl_mem[3] = 8'd0;  tbl_mem[4] = 8'd1;  tbl_mem[5] = 8'd2;
        tbl_mem[6] = 8'd40; tbl_mem[7] = 8'd7;  tbl_mem[959] = 8'd251;
        desc_mem[1] = {1'b0, 10'd0,   10'd6};
        desc_mem[2] = {1'b0, 10'd3,   10'd3};
        desc_mem[3] = {1'b1, 10'd6,   10'd2};
        desc_mem[4] = {1'b0, 10'd9,   10'd0};
        desc_mem[5] = {1'b0, 10'd959, 10'd1};
        desc_mem[6] = {1'b1, 10'd3,   10'd1};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_pcm_concat();
        t_shared_run();
        t_adpcm();
        t_ramp(2, "R6");
        t_ramp(6, "R6");
        t_retrigger();
        t_stop_plain();
        t_stop_ramp();
        t_reset_mid();
        t_empty();
        t_last_entry();
        repeat (5) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule